// File: doc/BRIEF.md
# Register Rename Table with Rollback History

This block gives each architectural register a current physical register and allocates a fresh physical register for every instruction that writes one. It owns the pool of unused physical registers and a per-register ready scoreboard. Every destination rename is logged in a history buffer ordered by sequence number, so later work can be cancelled or retired.

A cancel request carries a sequence number. The block then walks the history from the newest entry and undoes every rename younger than that number. A retire request also carries a sequence number. The block then walks the history from the oldest entry and releases each register that a retired rename made obsolete. A walk handles one entry per clock. `busy` stays high for the whole walk and no rename is accepted during it.

Architectural register 0 is hardwired. A rename of it logs an entry whose new and previous physical registers are both 0, and neither walk acts on such an entry.

Top module: `rename_map_hist`

## Requirements
- R1: After reset, `busy` and `cannot_rename` are low. Every architectural register `a` maps to physical register `a` and every scoreboard bit is ready. Physical registers ARCH_REGS..PHYS_REGS-1 are free, so the first allocation returns ARCH_REGS.
- R2: `src_phys` is the current mapping of `src_arch`, and `src_ready` is the scoreboard bit of that physical register. Both are combinational.
- R3: An accepted rename with `ren_has_dst`=1 and `ren_dst_arch`≠0 takes the lowest-numbered free physical register and returns it on `ren_phys`. It returns the old mapping on `ren_prev`, remaps the register from the next cycle on, marks the new register not ready and logs one history entry.
- R4: A `wb_valid` pulse marks physical register `wb_phys` ready from the next cycle on.
- R5: A rename of architectural register 0 allocates nothing and gives `ren_phys`=`ren_prev`=0. It logs an entry, but squash and commit walks remove that entry without any map restore or free. A rename with `ren_has_dst`=0 changes no state.
- R6: `cannot_rename` is high when `ren_valid` and `ren_has_dst` are high and either the history is full or a register is needed and none is free. The rename is then refused (`ren_ok`=0) and no state changes.
- R7: A squash removes history entries from the newest, one per cycle, while their sequence number exceeds `squash_seq`. Each removal restores the previous mapping and frees the new register. `busy` is high for (removed entries + 1) cycles.
- R8: A commit removes history entries from the oldest, one per cycle, while their sequence number is at most `commit_seq`. Each removal frees the previous register. `busy` is high for (removed entries + 1) cycles.
- R9: A commit when the history is empty, or when the oldest entry is younger than `commit_seq`, changes nothing and keeps `busy` high for exactly one cycle.
- R10: No rename is accepted while `busy` is high or in a cycle that carries a squash or commit request. If squash and commit are requested in the same cycle, the squash is performed and the commit is dropped. The history never grows during a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_arch | input | $clog2(ARCH_REGS) | Architectural source register to look up |
| src_phys | output | $clog2(PHYS_REGS) | Physical register currently mapped to `src_arch` |
| src_ready | output | 1 | Scoreboard ready bit of `src_phys` |
| ren_valid | input | 1 | Rename request |
| ren_has_dst | input | 1 | Request carries a destination register |
| ren_dst_arch | input | $clog2(ARCH_REGS) | Architectural destination register |
| ren_seq | input | SEQ_W | Sequence number of the renamed instruction |
| ren_ok | output | 1 | Rename accepted this cycle |
| ren_phys | output | $clog2(PHYS_REGS) | Physical register given to the destination |
| ren_prev | output | $clog2(PHYS_REGS) | Physical register the destination mapped to before |
| cannot_rename | output | 1 | Lack of free registers or history space |
| wb_valid | input | 1 | Result written back |
| wb_phys | input | $clog2(PHYS_REGS) | Physical register written back |
| squash_valid | input | 1 | Cancel request |
| squash_seq | input | SEQ_W | Renames younger than this are undone |
| commit_valid | input | 1 | Retire request |
| commit_seq | input | SEQ_W | Renames up to this number are retired |
| busy | output | 1 | A history walk is in progress |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. A register just allocated reads not ready on the next cycle. A refused rename is never accepted. The history never grows during a walk. The free pool never exceeds its reset size. At the end of a squash walk no logged entry is younger than the squash number, and at the end of a commit walk no retired entry is left.

Other behaviour needs whole scenarios, and the bench shows it by comparing every lookup with its own map, pool and history model. This covers the lowest-free allocation order after registers are recycled, the exact mappings a squash restores, which registers a commit frees, the busy length of each walk, squash winning over commit, and the refused renames when the pool or the history is exhausted.

// File: rtl/rmh_pkg.sv
`timescale 1ns/1ps
package rmh_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2
  } walk_e;
endpackage

// File: rtl/rmh_free_list.sv
`timescale 1ns/1ps
module rmh_free_list #(
  parameter int PHYS_REGS = 16,
  parameter int ARCH_REGS = 8,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          free_en,
  input  logic [PW-1:0] free_idx,
  output logic [PW-1:0] alloc_idx,
  output logic [PW:0]   avail_cnt
);
  localparam logic [PHYS_REGS-1:0] INIT_MASK = {PHYS_REGS{1'b1}} << ARCH_REGS;

  logic [PHYS_REGS-1:0] pool_q, pool_d;

  always_comb begin
    alloc_idx = '0;
    avail_cnt = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (pool_q[i]) alloc_idx = PW'(i);
    end
    for (int i = 0; i < PHYS_REGS; i++) begin
      avail_cnt = avail_cnt + (PW+1)'(pool_q[i]);
    end
  end

  always_comb begin
    pool_d = pool_q;
    if (alloc_en) pool_d[alloc_idx] = 1'b0;
    if (free_en)  pool_d[free_idx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pool_q <= INIT_MASK;
    else if (alloc_en || free_en) pool_q <= pool_d;
  end
endmodule

// File: rtl/rmh_history.sv
`timescale 1ns/1ps
module rmh_history #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 8,
  parameter int AW    = 3,
  parameter int PW    = 4,
  localparam int HW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [AW-1:0]    push_arch,
  input  logic [PW-1:0]    push_new,
  input  logic [PW-1:0]    push_prev,
  input  logic             pop_new_en,
  input  logic             pop_old_en,
  output logic [SEQ_W-1:0] new_seq,
  output logic [AW-1:0]    new_arch,
  output logic [PW-1:0]    new_new,
  output logic [PW-1:0]    new_prev,
  output logic [SEQ_W-1:0] old_seq,
  output logic [PW-1:0]    old_new,
  output logic [PW-1:0]    old_prev,
  output logic [HW:0]      cnt,
  output logic             full
);
  logic [SEQ_W-1:0] seq_m  [DEPTH];
  logic [AW-1:0]    arch_m [DEPTH];
  logic [PW-1:0]    new_m  [DEPTH];
  logic [PW-1:0]    prev_m [DEPTH];
  logic [HW-1:0]    wr_q, rd_q, wr_d, rd_d, top_idx;
  logic [HW:0]      cnt_q, cnt_d;

  function automatic logic [HW-1:0] step_up(input logic [HW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [HW-1:0] step_dn(input logic [HW-1:0] p);
    return (p == '0) ? HW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign top_idx  = step_dn(wr_q);
  assign new_seq  = seq_m[top_idx];
  assign new_arch = arch_m[top_idx];
  assign new_new  = new_m[top_idx];
  assign new_prev = prev_m[top_idx];
  assign old_seq  = seq_m[rd_q];
  assign old_new  = new_m[rd_q];
  assign old_prev = prev_m[rd_q];
  assign cnt      = cnt_q;
  assign full     = (int'(cnt_q) == DEPTH);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_en)    begin wr_d = step_up(wr_q); cnt_d = cnt_d + 1'b1; end
    if (pop_new_en) begin wr_d = step_dn(wr_q); cnt_d = cnt_d - 1'b1; end
    if (pop_old_en) begin rd_d = step_up(rd_q); cnt_d = cnt_d - 1'b1; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (push_en || pop_new_en || pop_old_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) begin
      seq_m[wr_q]  <= push_seq;
      arch_m[wr_q] <= push_arch;
      new_m[wr_q]  <= push_new;
      prev_m[wr_q] <= push_prev;
    end
  end
endmodule

// File: rtl/rmh_map_sb.sv
`timescale 1ns/1ps
module rmh_map_sb #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 map_wr_en,
  input  logic [AW-1:0]        map_wr_arch,
  input  logic [PW-1:0]        map_wr_phys,
  input  logic [AW-1:0]        rd_a_arch,
  output logic [PW-1:0]        rd_a_phys,
  input  logic [AW-1:0]        rd_b_arch,
  output logic [PW-1:0]        rd_b_phys,
  input  logic                 rdy_clr_en,
  input  logic [PW-1:0]        rdy_clr_idx,
  input  logic                 rdy_set_en,
  input  logic [PW-1:0]        rdy_set_idx,
  output logic [PHYS_REGS-1:0] ready_vec
);
  logic [PW-1:0]        map_q [ARCH_REGS];
  logic [PHYS_REGS-1:0] rdy_q, rdy_d;

  assign rd_a_phys = map_q[rd_a_arch];
  assign rd_b_phys = map_q[rd_b_arch];
  assign ready_vec = rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else if (map_wr_en) begin
      map_q[map_wr_arch] <= map_wr_phys;
    end
  end

  always_comb begin
    rdy_d = rdy_q;
    if (rdy_set_en) rdy_d[rdy_set_idx] = 1'b1;
    if (rdy_clr_en) rdy_d[rdy_clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rdy_q <= '1;
    else if (rdy_set_en || rdy_clr_en) rdy_q <= rdy_d;
  end
endmodule

// File: rtl/rename_map_hist.sv
`timescale 1ns/1ps
module rename_map_hist
  import rmh_pkg::*;
#(
  parameter int ARCH_REGS  = 8,
  parameter int PHYS_REGS  = 16,
  parameter int HIST_DEPTH = 16,
  parameter int SEQ_W      = 8,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int HW = $clog2(HIST_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    src_arch,
  output logic [PW-1:0]    src_phys,
  output logic             src_ready,
  input  logic             ren_valid,
  input  logic             ren_has_dst,
  input  logic [AW-1:0]    ren_dst_arch,
  input  logic [SEQ_W-1:0] ren_seq,
  output logic             ren_ok,
  output logic [PW-1:0]    ren_phys,
  output logic [PW-1:0]    ren_prev,
  output logic             cannot_rename,
  input  logic             wb_valid,
  input  logic [PW-1:0]    wb_phys,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  output logic             busy
);
  walk_e            walk_q, walk_d;
  logic [SEQ_W-1:0] walk_seq_q, walk_seq_d;

  logic [PW-1:0]    alloc_idx;
  logic [PW:0]      avail_cnt;
  logic [SEQ_W-1:0] new_seq, old_seq;
  logic [AW-1:0]    new_arch;
  logic [PW-1:0]    new_new, new_prev, old_new, old_prev;
  logic [HW:0]      hist_cnt;
  logic             hist_full;
  logic [PHYS_REGS-1:0] ready_vec;

  logic needs_alloc, ren_alloc, sq_hit, cm_hit, pop_new, pop_old;
  logic restore, free_en, map_wr_en;
  logic [PW-1:0] free_idx;
  logic [AW-1:0] map_wr_arch;
  logic [PW-1:0] map_wr_phys;

  assign busy          = (walk_q != WALK_IDLE);
  assign needs_alloc   = ren_has_dst && (ren_dst_arch != '0);
  assign cannot_rename = ren_valid && ren_has_dst &&
                         (hist_full || (needs_alloc && avail_cnt == '0));
  assign ren_ok        = ren_valid && !busy && !squash_valid && !commit_valid && !cannot_rename;
  assign ren_alloc     = ren_ok && needs_alloc;
  assign ren_phys      = needs_alloc ? alloc_idx : ren_prev;
  assign src_ready     = ready_vec[src_phys];

  assign sq_hit  = (hist_cnt != '0) && (new_seq > walk_seq_q);
  assign cm_hit  = (hist_cnt != '0) && (old_seq <= walk_seq_q);
  assign pop_new = (walk_q == WALK_SQUASH) && sq_hit;
  assign pop_old = (walk_q == WALK_COMMIT) && cm_hit;
  assign restore = pop_new && (new_new != new_prev);
  assign free_en = restore || (pop_old && (old_new != old_prev));
  assign free_idx = pop_new ? new_new : old_prev;

  assign map_wr_en   = ren_alloc || restore;
  assign map_wr_arch = ren_alloc ? ren_dst_arch : new_arch;
  assign map_wr_phys = ren_alloc ? alloc_idx : new_prev;

  always_comb begin
    walk_d     = walk_q;
    walk_seq_d = walk_seq_q;
    unique case (walk_q)
      WALK_IDLE: begin
        if (squash_valid) begin
          walk_d = WALK_SQUASH; walk_seq_d = squash_seq;
        end else if (commit_valid) begin
          walk_d = WALK_COMMIT; walk_seq_d = commit_seq;
        end
      end
      WALK_SQUASH: if (!sq_hit) walk_d = WALK_IDLE;
      WALK_COMMIT: if (!cm_hit) walk_d = WALK_IDLE;
      default:     walk_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_q     <= WALK_IDLE;
      walk_seq_q <= '0;
    end else begin
      walk_q     <= walk_d;
      walk_seq_q <= walk_seq_d;
    end
  end

  rmh_free_list #(.PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS)) u_free (
    .clk(clk), .rst_n(rst_n), .alloc_en(ren_alloc), .free_en(free_en),
    .free_idx(free_idx), .alloc_idx(alloc_idx), .avail_cnt(avail_cnt)
  );

  rmh_history #(.DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .AW(AW), .PW(PW)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .push_en(ren_ok && ren_has_dst), .push_seq(ren_seq), .push_arch(ren_dst_arch),
    .push_new(ren_phys), .push_prev(ren_prev),
    .pop_new_en(pop_new), .pop_old_en(pop_old),
    .new_seq(new_seq), .new_arch(new_arch), .new_new(new_new), .new_prev(new_prev),
    .old_seq(old_seq), .old_new(old_new), .old_prev(old_prev),
    .cnt(hist_cnt), .full(hist_full)
  );

  rmh_map_sb #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk(clk), .rst_n(rst_n),
    .map_wr_en(map_wr_en), .map_wr_arch(map_wr_arch), .map_wr_phys(map_wr_phys),
    .rd_a_arch(src_arch), .rd_a_phys(src_phys),
    .rd_b_arch(ren_dst_arch), .rd_b_phys(ren_prev),
    .rdy_clr_en(ren_alloc), .rdy_clr_idx(alloc_idx),
    .rdy_set_en(wb_valid), .rdy_set_idx(wb_phys),
    .ready_vec(ready_vec)
  );
endmodule

// File: rtl/rename_map_hist_chk.sv
`timescale 1ns/1ps
module rename_map_hist_chk
  import rmh_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int SEQ_W     = 8,
  parameter int AW        = 3,
  parameter int PW        = 4,
  parameter int HW        = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ren_ok,
  input logic                 ren_has_dst,
  input logic [AW-1:0]        ren_dst_arch,
  input logic [PW-1:0]        ren_phys,
  input logic                 cannot_rename,
  input logic                 busy,
  input logic [1:0]           walk_st,
  input logic [SEQ_W-1:0]     walk_seq,
  input logic [HW:0]          hist_cnt,
  input logic [SEQ_W-1:0]     newest_seq,
  input logic [SEQ_W-1:0]     oldest_seq,
  input logic [PW:0]          avail_cnt,
  input logic [PHYS_REGS-1:0] ready_vec
);
  // R3
  alloc_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_ok && ren_has_dst && ren_dst_arch != '0) |=> !ready_vec[$past(ren_phys)]);

  // R5
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_ok && ren_has_dst && ren_dst_arch == '0) |-> ren_phys == '0);

  // R6
  refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cannot_rename |-> !ren_ok);

  // R10
  no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> hist_cnt <= $past(hist_cnt));

  // R7
  squash_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(walk_st) == 2'(WALK_SQUASH)) |-> (hist_cnt == '0 || newest_seq <= walk_seq));

  // R8
  commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(walk_st) == 2'(WALK_COMMIT)) |-> (hist_cnt == '0 || oldest_seq > walk_seq));

  // R1
  pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(avail_cnt) <= PHYS_REGS - ARCH_REGS);
endmodule

bind rename_map_hist rename_map_hist_chk #(
  .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .SEQ_W(SEQ_W), .AW(AW), .PW(PW), .HW(HW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_ok(ren_ok), .ren_has_dst(ren_has_dst),
  .ren_dst_arch(ren_dst_arch), .ren_phys(ren_phys), .cannot_rename(cannot_rename),
  .busy(busy), .walk_st(walk_q), .walk_seq(walk_seq_q), .hist_cnt(hist_cnt),
  .newest_seq(new_seq), .oldest_seq(old_seq), .avail_cnt(avail_cnt), .ready_vec(ready_vec)
);

// File: tb/tb_rename_map_hist.sv
`timescale 1ns/1ps
module tb_rename_map_hist;
  localparam int NA = 8, NP = 16, ND = 16, SW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] src_arch = '0, ren_dst_arch = '0;
  logic [3:0] src_phys, ren_phys, ren_prev, wb_phys = '0;
  logic src_ready, ren_ok, cannot_rename, busy;
  logic ren_valid = 0, ren_has_dst = 0, wb_valid = 0, squash_valid = 0, commit_valid = 0;
  logic [SW-1:0] ren_seq = '0, squash_seq = '0, commit_seq = '0;

  always #5 clk = ~clk;

  rename_map_hist #(.ARCH_REGS(NA), .PHYS_REGS(NP), .HIST_DEPTH(ND), .SEQ_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .src_arch(src_arch), .src_phys(src_phys), .src_ready(src_ready),
    .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_dst_arch(ren_dst_arch),
    .ren_seq(ren_seq), .ren_ok(ren_ok), .ren_phys(ren_phys), .ren_prev(ren_prev),
    .cannot_rename(cannot_rename), .wb_valid(wb_valid), .wb_phys(wb_phys),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .commit_valid(commit_valid),
    .commit_seq(commit_seq), .busy(busy)
  );

  int n_chk = 0, n_bad = 0, cur_seq = 1;
  int m_map[NA];
  bit m_free[NP];
  bit m_rdy[NP];
  int h_seq[ND], h_arch[ND], h_new[ND], h_prev[ND];
  int h_n = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int low_free();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic sweep(string req);
    for (int a = 0; a < NA; a++) begin
      @(negedge clk); src_arch = 3'(a); #1;
      chk(req, int'(src_phys), m_map[a]);
      chk(req, int'(src_ready), int'(m_rdy[m_map[a]]));
    end
  endtask

  task automatic do_ren(bit has, int dst, string req);
    bit need, cant; int lf;
    @(negedge clk);
    ren_valid = 1; ren_has_dst = has; ren_dst_arch = 3'(dst); ren_seq = SW'(cur_seq);
    #1;
    need = has && dst != 0;
    lf   = low_free();
    cant = has && (h_n == ND || (need && lf < 0));
    chk(req, int'(cannot_rename), int'(cant));
    chk(req, int'(ren_ok), int'(!cant));
    if (!cant && has) begin
      chk(req, int'(ren_prev), m_map[dst]);
      chk(req, int'(ren_phys), need ? lf : m_map[dst]);
    end
    @(posedge clk); #1;
    ren_valid = 0;
    if (!cant && has) begin
      h_seq[h_n] = cur_seq; h_arch[h_n] = dst; h_prev[h_n] = m_map[dst];
      h_new[h_n] = need ? lf : m_map[dst];
      h_n++;
      if (need) begin m_map[dst] = lf; m_free[lf] = 0; m_rdy[lf] = 0; end
    end
    if (!cant) cur_seq++;
  endtask

  task automatic do_wb(int p);
    @(negedge clk); wb_valid = 1; wb_phys = 4'(p);
    @(posedge clk); #1; wb_valid = 0; m_rdy[p] = 1;
  endtask

  // is_sq: squash (1) or commit (0); both: raise commit too; poke: try a rename while busy
  task automatic do_walk(bit is_sq, int s, bit both, bit poke, string req);
    int n, cyc;
    @(negedge clk);
    if (is_sq) begin squash_valid = 1; squash_seq = SW'(s); end
    else begin commit_valid = 1; commit_seq = SW'(s); end
    if (both) begin commit_valid = 1; commit_seq = SW'(255); end
    @(posedge clk); #1;
    squash_valid = 0; commit_valid = 0;
    n = 0;
    if (is_sq) begin
      while (n < h_n && h_seq[h_n-1-n] > s) n++;
    end else begin
      while (n < h_n && h_seq[n] <= s) n++;
    end
    cyc = 0;
    @(negedge clk);
    if (poke && busy) begin
      ren_valid = 1; ren_has_dst = 1; ren_dst_arch = 3'd3; #1;
      chk("R10 rename while busy", int'(ren_ok), 0);
      ren_valid = 0;
    end
    while (busy && cyc < 100) begin cyc++; @(negedge clk); end
    chk(is_sq ? "R7 busy cycles" : (n == 0 ? "R9 busy cycles" : "R8 busy cycles"), cyc, n + 1);
    if (is_sq) begin
      for (int k = 0; k < n; k++) begin
        int e; e = h_n - 1;
        if (h_new[e] != h_prev[e]) begin m_map[h_arch[e]] = h_prev[e]; m_free[h_new[e]] = 1; end
        h_n--;
      end
    end else begin
      for (int k = 0; k < n; k++) if (h_new[k] != h_prev[k]) m_free[h_prev[k]] = 1;
      for (int k = n; k < h_n; k++) begin
        h_seq[k-n] = h_seq[k]; h_arch[k-n] = h_arch[k]; h_new[k-n] = h_new[k]; h_prev[k-n] = h_prev[k];
      end
      h_n -= n;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < NA; a++) m_map[a] = a;
    for (int p = 0; p < NP; p++) begin m_free[p] = (p >= NA); m_rdy[p] = 1; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 cannot_rename after reset", int'(cannot_rename), 0);
    sweep("R1 identity map");
    do_ren(1, 1, "R1 first allocation");
    do_ren(1, 2, "R3 allocation");
    do_ren(1, 0, "R5 zero destination");
    do_ren(0, 5, "R5 no destination");
    do_ren(1, 1, "R3 rename again");
    for (int d = 3; d <= 7; d++) do_ren(1, d, "R3 fill pool");
    sweep("R2 lookup after renames");
    do_ren(1, 4, "R6 pool empty");
    do_ren(1, 0, "R5 zero destination with empty pool");
    do_wb(10); do_wb(12);
    sweep("R4 writeback ready");
    do_walk(1, 5, 0, 1, "R7 squash");
    sweep("R7 map restored");
    do_ren(1, 6, "R3 reuse after squash");
    do_walk(0, 2, 0, 0, "R8 commit");
    do_walk(0, 1, 0, 0, "R9 commit older than oldest");
    sweep("R8 map after commit");
    do_ren(1, 5, "R3 lowest free after commit");
    do_walk(1, cur_seq - 2, 1, 0, "R10 squash wins");
    sweep("R10 squash over commit");
    do_walk(0, 255, 0, 0, "R8 commit all");
    do_walk(0, 255, 0, 0, "R9 commit empty");
    for (int k = 0; k < ND; k++) do_ren(1, 0, "R5 fill history");
    do_ren(1, 0, "R6 history full");
    do_ren(1, 2, "R6 history full with alloc");
    do_walk(0, 255, 0, 0, "R8 drain zero entries");
    sweep("R5 zero entries leave map");
    for (int it = 0; it < 140; it++) begin
      int op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = int'(lfsr[3:0]);
      if (cur_seq > 240) op = 15;
      if (op < 8)       do_ren(lfsr[4] | lfsr[5], int'(lfsr[8:6]), "R3 mixed rename");
      else if (op < 10) do_wb(int'(lfsr[11:8]));
      else if (op < 13) do_walk(1, cur_seq - 1 - int'(lfsr[6:5]), 0, lfsr[7], "R7 mixed squash");
      else              do_walk(0, cur_seq - 1 - int'(lfsr[7:5]), 0, 0, "R8 mixed commit");
      if (it % 10 == 9) sweep("R2 mixed lookup");
    end
    sweep("R2 final lookup");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule